// File: doc/BRIEF.md
# Oversampled XOR Phase Detector for Clock Recovery

This block is a digital model of a linear clock-recovery phase detector. A fast system clock oversamples the serial data stream. A level input gives the phase of the recovered bit clock: high for the first half of each bit period and low for the second half. A strobe marks the system-clock cycles that carry one oversample. A rising edge of the recovered-clock phase, seen across two strobed samples, is a bit boundary. At that point a register retimes the data. A latch copies the register while the recovered-clock phase is low.

Two exclusive-OR comparisons form an early pulse and a late pulse. The early pulse marks where the input disagrees with the register. Its width is the distance from a data edge to the next boundary. The late pulse marks where the register disagrees with the latch. It lasts exactly the high half of the bit that follows a captured transition. The block counts strobed samples of each pulse and issues one signed error word per bit. When the data edge sits on the falling recovered-clock edge, the word is zero. No word is non-zero until the stream has shown a real transition.

A balanced mode adds a second latch that follows the first while the phase is high. It adds a third pulse with weight +1 and doubles the weight of the late pulse. The error per edge then has no low-frequency residue that depends on the data pattern. The recovered-clock source, charge pump and loop filter sit outside this block.

Top module: `xor_cdr_pd`

## Requirements
- R1: A synchronous active-high reset clears the retiming register, both latches, the counters and every output. Outputs read 0 while reset is held.
- R2: A bit boundary is a strobed sample with `rclk_ph`=1 where the previous strobed sample had `rclk_ph`=0. The register captures `din_os` on that sample, and `rtm_data` shows the captured value from the next clock.
- R3: Clock cycles with `smp_stb`=0 are ignored. Input values on those cycles change no count, no retimed bit and no pulse output. `err_valid` stays 0 on the clock after a cycle without a strobe.
- R4: The early pulse is 1 on every strobed sample where `din_os` differs from the retimed bit, counting a boundary sample's fresh capture. `up_pulse` shows it one clock after that strobe.
- R5: The late pulse is 1 on strobed samples where the retimed bit differs from the latch. The latch follows the register whenever `rclk_ph`=0. After each captured transition the late pulse therefore lasts OSR/2 strobed samples, starting at the boundary. `dn_pulse` shows it one clock after that strobe.
- R6: `err_valid` pulses for one clock after every boundary strobe. It reports the capture made at the boundary before: `bit_flip` is 1 when that captured bit differs from the bit captured one boundary earlier. `phase_err` is the early count of the bit period ending at that capture minus the late count that follows it.
- R7: With OSR=16 and a 50% recovered-clock duty, a data edge that arrives at strobed sample k (1 to 15) of the bit period before its capture gives `phase_err` = 8 − k. An edge at the falling phase edge (k=8) gives 0.
- R8: A stream that holds its level with no short pulse reports `bit_flip`=0 and `phase_err`=0.
- R9: Until the first report with `bit_flip`=1, `phase_err` is forced to 0. After that, a short pulse of g samples that the register does not capture reports `phase_err`=g with `bit_flip`=0.
- R10: With `balanced`=1, the error is the early count minus twice the late count plus the count of a third pulse. The third pulse marks where the first latch differs from a second latch, which follows the first while `rclk_ph`=1. The R7 and R9 values still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Marks a cycle that carries one oversample |
| din_os | input | 1 | Oversampled serial data |
| rclk_ph | input | 1 | Recovered-clock phase level, high in first half of bit |
| balanced | input | 1 | Selects the balanced +1/−2/+1 weighting |
| rtm_data | output | 1 | Retimed data bit |
| up_pulse | output | 1 | Early pulse, registered per strobe |
| dn_pulse | output | 1 | Late pulse, registered per strobe |
| phase_err | output | ERR_W | Signed phase error for one bit, two's complement |
| err_valid | output | 1 | One-clock strobe marking a new error word |
| bit_flip | output | 1 | Reported bit differs from its predecessor |

## Verification
A data edge placed in one bit period is captured at the next boundary. The late and third pulses of that edge fill the following bit, so its error word appears one clock after the boundary after that, two bit periods after the edge. The bench pushes each expected word into a queue when it drives the bit and pops an entry at every `err_valid` it sees. It reads `rtm_data` one clock after the boundary sample. It counts `up_pulse` and `dn_pulse` one clock behind each strobe. All outputs are sampled on the falling clock edge. Each scenario ends with two steady bits so that every word it expects has arrived before it checks the queue length.

// File: rtl/xpd_pkg.sv
package xpd_pkg;
  // Pulse bundle produced once per strobed sample
  typedef struct packed {
    logic up;   // early pulse, weight +1
    logic dn;   // late pulse, weight -1 (or -2 when balanced)
    logic up2;  // trailing pulse of the balanced variant, weight +1
  } pulse_t;
endpackage

// File: rtl/xpd_retime.sv
module xpd_retime
  import xpd_pkg::*;
#(
  parameter bit ENABLE_BAL = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   stb,
  input  logic   din,
  input  logic   rclk,
  output logic   rise,
  output logic   reg_q,
  output logic   flip,
  output pulse_t pls
);
  logic rclk_d;
  logic prev_q;
  logic lat1_q;
  logic reg_now;
  logic lat1_now;
  logic up2_w;

  // boundary: phase high now, low on the previous strobed sample
  assign rise     = rclk & ~rclk_d;
  assign reg_now  = rise ? din : reg_q;
  // first latch is transparent while the phase is low
  assign lat1_now = rclk ? lat1_q : reg_now;
  assign flip     = reg_q ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rclk_d <= 1'b0;
      reg_q  <= 1'b0;
      lat1_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (stb) begin
      rclk_d <= rclk;
      reg_q  <= reg_now;
      lat1_q <= lat1_now;
      if (rise) prev_q <= reg_q;
    end
  end

  generate
    if (ENABLE_BAL) begin : g_bal
      logic lat2_q;
      logic lat2_now;
      // second latch is transparent while the phase is high
      assign lat2_now = rclk ? lat1_now : lat2_q;
      assign up2_w    = lat1_now ^ lat2_now;
      always_ff @(posedge clk) begin
        if (rst)      lat2_q <= 1'b0;
        else if (stb) lat2_q <= lat2_now;
      end
    end else begin : g_nobal
      assign up2_w = 1'b0;
    end
  endgenerate

  assign pls = '{up: din ^ reg_now, dn: reg_now ^ lat1_now, up2: up2_w};
endmodule

// File: rtl/xpd_accum.sv
module xpd_accum
  import xpd_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int ERR_W      = 6,
  parameter bit ENABLE_BAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic             rise,
  input  logic             bal_mode,
  input  pulse_t           pls,
  input  logic             flip,
  output logic [ERR_W-1:0] err_q,
  output logic             vld_q,
  output logic             flip_q
);
  localparam int CNT_W = $clog2(OSR) + 1;
  localparam int SUM_W = (CNT_W + 3 > ERR_W + 1) ? CNT_W + 3 : ERR_W + 1;
  localparam int E_MAX = 2 ** (ERR_W - 1) - 1;
  localparam logic signed [SUM_W-1:0] LIM_HI = SUM_W'(E_MAX);
  localparam logic signed [SUM_W-1:0] LIM_LO = SUM_W'(-E_MAX - 1);

  logic [CNT_W-1:0] up_acc, up_hold, dn_acc, up2_acc;
  logic             seen_q;
  logic             bal_eff;
  logic signed [SUM_W-1:0] e_up, e_dn, e_up2, e_sum, e_sat;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic p);
    if (p && (c != '1)) return c + CNT_W'(1);
    return c;
  endfunction

  function automatic logic signed [SUM_W-1:0] widen(input logic [CNT_W-1:0] c);
    return $signed({{(SUM_W - CNT_W){1'b0}}, c});
  endfunction

  assign bal_eff = bal_mode & ENABLE_BAL;

  always_comb begin
    e_up  = widen(up_hold);
    e_dn  = widen(dn_acc);
    e_up2 = widen(up2_acc);
    if (bal_eff) e_sum = e_up - (e_dn <<< 1) + e_up2;
    else         e_sum = e_up - e_dn;
    if (e_sum > LIM_HI)      e_sat = LIM_HI;
    else if (e_sum < LIM_LO) e_sat = LIM_LO;
    else                     e_sat = e_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_acc  <= '0;
      up_hold <= '0;
      dn_acc  <= '0;
      up2_acc <= '0;
      seen_q  <= 1'b0;
      err_q   <= '0;
      vld_q   <= 1'b0;
      flip_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (stb) begin
        if (rise) begin
          vld_q   <= 1'b1;
          flip_q  <= flip;
          err_q   <= (seen_q | flip) ? e_sat[ERR_W-1:0] : '0;
          seen_q  <= seen_q | flip;
          up_hold <= up_acc;
          up_acc  <= {{(CNT_W-1){1'b0}}, pls.up};
          dn_acc  <= {{(CNT_W-1){1'b0}}, pls.dn};
          up2_acc <= {{(CNT_W-1){1'b0}}, pls.up2};
        end else begin
          up_acc  <= bump(up_acc, pls.up);
          dn_acc  <= bump(dn_acc, pls.dn);
          up2_acc <= bump(up2_acc, pls.up2);
        end
      end
    end
  end
endmodule

// File: rtl/xor_cdr_pd.sv
module xor_cdr_pd
  import xpd_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int ERR_W      = 6,
  parameter bit ENABLE_BAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_stb,
  input  logic             din_os,
  input  logic             rclk_ph,
  input  logic             balanced,
  output logic             rtm_data,
  output logic             up_pulse,
  output logic             dn_pulse,
  output logic [ERR_W-1:0] phase_err,
  output logic             err_valid,
  output logic             bit_flip
);
  pulse_t pls;
  logic   rise;
  logic   flip;

  xpd_retime #(.ENABLE_BAL(ENABLE_BAL)) u_retime (
    .clk  (clk),
    .rst  (rst),
    .stb  (smp_stb),
    .din  (din_os),
    .rclk (rclk_ph),
    .rise (rise),
    .reg_q(rtm_data),
    .flip (flip),
    .pls  (pls)
  );

  xpd_accum #(.OSR(OSR), .ERR_W(ERR_W), .ENABLE_BAL(ENABLE_BAL)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .stb     (smp_stb),
    .rise    (rise),
    .bal_mode(balanced),
    .pls     (pls),
    .flip    (flip),
    .err_q   (phase_err),
    .vld_q   (err_valid),
    .flip_q  (bit_flip)
  );

  // registered view of the early and late pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      up_pulse <= 1'b0;
      dn_pulse <= 1'b0;
    end else if (smp_stb) begin
      up_pulse <= pls.up;
      dn_pulse <= pls.dn;
    end
  end
endmodule

// File: rtl/xor_cdr_pd_chk.sv
module xor_cdr_pd_chk #(
  parameter int OSR   = 16,
  parameter int ERR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_stb,
  input logic             rclk_ph,
  input logic             rtm_data,
  input logic             up_pulse,
  input logic             dn_pulse,
  input logic [ERR_W-1:0] phase_err,
  input logic             err_valid,
  input logic             bit_flip
);
  localparam int HALF = OSR / 2;

  assert_no_report_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> !err_valid);

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> ($stable(rtm_data) && $stable(up_pulse) && $stable(dn_pulse)));

  assert_up_strobed_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(up_pulse) |-> $past(smp_stb));

  assert_dn_high_phase_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_pulse) |-> ($past(smp_stb) && $past(rclk_ph)));

  assert_report_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> ($past(smp_stb) && $past(rclk_ph)));

  // holds for a 50% recovered-clock duty
  assert_err_span_R7: assert property (@(posedge clk) disable iff (rst)
    (err_valid && bit_flip) |->
      (($signed(phase_err) >= -HALF) && ($signed(phase_err) <= HALF - 1)));
endmodule

bind xor_cdr_pd xor_cdr_pd_chk #(.OSR(OSR), .ERR_W(ERR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_stb  (smp_stb),
  .rclk_ph  (rclk_ph),
  .rtm_data (rtm_data),
  .up_pulse (up_pulse),
  .dn_pulse (dn_pulse),
  .phase_err(phase_err),
  .err_valid(err_valid),
  .bit_flip (bit_flip)
);

// File: tb/xor_cdr_pd_tb.sv
`timescale 1ns/1ps
module xor_cdr_pd_tb;
  localparam int OSR   = 16;
  localparam int ERR_W = 6;
  localparam int HALF  = OSR / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic din_os = 1'b0;
  logic rclk_ph = 1'b0;
  logic balanced = 1'b0;
  logic rtm_data, up_pulse, dn_pulse, err_valid, bit_flip;
  logic [ERR_W-1:0] phase_err;

  xor_cdr_pd #(.OSR(OSR), .ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .din_os(din_os), .rclk_ph(rclk_ph),
    .balanced(balanced), .rtm_data(rtm_data), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
    .phase_err(phase_err), .err_valid(err_valid), .bit_flip(bit_flip)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit mon_on = 1'b0;
  bit gap_mode = 1'b0;
  bit seen_m = 1'b0;
  bit cur = 1'b0;
  int up_seen = 0;
  int dn_seen = 0;
  int    q_err[$];
  bit    q_tr[$];
  string q_tag[$];

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // report monitor and pulse counters
  always @(negedge clk) begin
    if (mon_on) begin
      up_seen += int'(up_pulse);
      dn_seen += int'(dn_pulse);
      if (err_valid) begin
        if (q_err.size() == 0) chk("R6 unexpected report", 1, 0);
        else begin
          int    e;
          bit    t;
          string g;
          e = q_err.pop_front();
          t = q_tr.pop_front();
          g = q_tag.pop_front();
          chk({g, " flip"}, int'(bit_flip), int'(t));
          chk({g, " err"}, int'($signed(phase_err)), e);
        end
      end
    end
  end

  task automatic push(input int e, input bit t, input string g);
    q_err.push_back(e);
    q_tr.push_back(t);
    q_tag.push_back(g);
  endtask

  task automatic do_reset(input bit bal);
    mon_on = 1'b0;
    @(negedge clk);
    rst = 1'b1; smp_stb = 1'b0; din_os = 1'b0; rclk_ph = 1'b0; balanced = bal;
    repeat (3) @(negedge clk);
    q_err.delete(); q_tr.delete(); q_tag.delete();
    cur = 1'b0; seen_m = 1'b0; up_seen = 0; dn_seen = 0;
    push(0, 1'b0, "R6 startup");
    push(0, 1'b0, "R6 startup");
    rst = 1'b0;
    mon_on = 1'b1;
  endtask

  task automatic sample(input bit d, input bit r, input int rd_exp, input string g);
    @(negedge clk);
    if (rd_exp >= 0) chk(g, int'(rtm_data), rd_exp);
    din_os = d; rclk_ph = r; smp_stb = 1'b1;
    if (gap_mode) begin
      @(negedge clk);
      smp_stb = 1'b0; din_os = ~d; rclk_ph = ~r;
    end
  endtask

  // one bit period: edge to nb at sample k, optional short pulse gs..gs+gw-1
  task automatic send_bit(input bit nb, input int k, input int gs, input int gw, input string g);
    bit tr;
    int e;
    tr = nb ^ cur;
    for (int s = 0; s < OSR; s++) begin
      bit d;
      d = (s < k) ? cur : nb;
      if (gw > 0 && s >= gs && s < gs + gw) d = ~d;
      sample(d, (s < HALF), (s == 1) ? int'(cur) : -1, {g, " R2 retimed bit"});
    end
    e = tr ? (HALF - k) : gw;
    if (!tr && !seen_m) e = 0;
    if (tr) seen_m = 1'b1;
    push(e, tr, g);
    cur = nb;
  endtask

  task automatic finish_scn(input string g);
    send_bit(cur, OSR, 0, 0, "flush");
    send_bit(cur, OSR, 0, 0, "flush");
    chk({g, " R6 reports delivered"}, q_err.size(), 2);
  endtask

  task automatic test_sweep;
    do_reset(1'b0);
    send_bit(1'b1, 1, 0, 0, "R7 edge k=1");
    send_bit(1'b0, 4, 0, 0, "R7 edge k=4");
    send_bit(1'b1, 12, 0, 0, "R7 edge k=12");
    send_bit(1'b0, 15, 0, 0, "R7 edge k=15");
    send_bit(1'b1, 8, 0, 0, "R7 edge k=8");
    finish_scn("sweep");
  endtask

  task automatic test_reset;
    @(negedge clk);
    rst = 1'b1; mon_on = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 rtm_data", int'(rtm_data), 0);
    chk("R1 err_valid", int'(err_valid), 0);
    chk("R1 phase_err", int'(phase_err), 0);
    chk("R1 bit_flip", int'(bit_flip), 0);
    chk("R1 up_pulse", int'(up_pulse), 0);
    chk("R1 dn_pulse", int'(dn_pulse), 0);
  endtask

  task automatic test_center;
    do_reset(1'b0);
    send_bit(1'b1, 8, 0, 0, "R6 centred rise");
    send_bit(1'b0, 8, 0, 0, "R6 centred fall");
    send_bit(1'b1, 8, 0, 0, "R7 centred rise");
    send_bit(1'b0, 8, 0, 0, "R7 centred fall");
    finish_scn("center");
  endtask

  task automatic test_flat;
    do_reset(1'b0);
    send_bit(1'b1, 5, 0, 0, "R7 edge k=5");
    send_bit(1'b1, OSR, 0, 0, "R8 steady");
    send_bit(1'b1, OSR, 0, 0, "R8 steady");
    send_bit(1'b1, OSR, 0, 0, "R8 steady");
    finish_scn("flat");
  endtask

  task automatic test_glitch;
    do_reset(1'b0);
    send_bit(1'b0, OSR, 4, 3, "R9 pulse before first edge");
    send_bit(1'b1, 8, 0, 0, "R9 first edge");
    send_bit(1'b1, OSR, 2, 5, "R9 pulse after edge");
    finish_scn("glitch");
  endtask

  task automatic test_gaps;
    gap_mode = 1'b1;
    do_reset(1'b0);
    send_bit(1'b1, 5, 0, 0, "R3 gapped k=5");
    send_bit(1'b0, 10, 0, 0, "R3 gapped k=10");
    send_bit(1'b0, OSR, 3, 2, "R3 gapped pulse");
    finish_scn("gaps");
    gap_mode = 1'b0;
  endtask

  task automatic test_pulses;
    do_reset(1'b0);
    send_bit(1'b1, 6, 0, 0, "R7 edge k=6");
    send_bit(1'b1, OSR, 0, 0, "R8 steady");
    finish_scn("pulses");
    chk("R4 early pulse samples", up_seen, OSR - 6);
    chk("R5 late pulse samples", dn_seen, HALF);
  endtask

  task automatic test_balanced;
    do_reset(1'b1);
    send_bit(1'b1, 3, 0, 0, "R10 edge k=3");
    send_bit(1'b0, 8, 0, 0, "R10 edge k=8");
    send_bit(1'b1, 13, 0, 0, "R10 edge k=13");
    send_bit(1'b1, OSR, 5, 4, "R10 pulse");
    finish_scn("balanced");
  endtask

  initial begin
    #4000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_sweep();
    test_reset();
    test_center();
    test_flat();
    test_glitch();
    test_gaps();
    test_pulses();
    test_balanced();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule